// File: doc/BRIEF.md
# Hysteretic Dual-Precision Mode Controller

This block selects the working precision of a fixed-point datapath from one activity or gradient magnitude per sample. In the coarse mode it holds a single state word as an 8-bit value with four fraction bits (Q4.4). In the fine mode it holds the same word as a 16-bit value with eight fraction bits (Q8.8). Two separate thresholds form a hysteresis band, so that a magnitude that wanders near a single boundary cannot make the mode flip back and forth.

Each valid sample carries an unsigned Q8.8 magnitude and a signed Q8.8 update. The update is accumulated into the state with saturation, at the precision of the mode in force before the sample. The magnitude then decides the mode for the next sample. When the mode flips, the stored word is converted to the new format, with rounding and saturation where needed. The current mode, a one-cycle change pulse and the state are all registered outputs. In coarse mode the state output is the Q4.4 value, sign-extended to 16 bits.

Top module: `prec_mode_ctrl`

## Requirements
- R1: While reset is active, and in the cycle after it is released, the block is in coarse mode (`hi_mode_o`=0), `state_o`=0 and `mode_chg_o`=0.
- R2: In coarse mode, a valid sample with magnitude strictly greater than 26 (0.1 in Q8.8, rounded to nearest) switches the block to fine mode. A magnitude of exactly 26 leaves it in coarse mode.
- R3: In fine mode, a valid sample with magnitude strictly less than 13 (0.05 in Q8.8) switches the block to coarse mode. A magnitude of exactly 13 leaves it in fine mode.
- R4: A valid sample with a magnitude from 13 to 26 inclusive never changes the mode, whichever mode is current.
- R5: `mode_chg_o` is 1 for exactly one cycle, in the cycle where `hi_mode_o` first shows a new value, and is 0 at all other times.
- R6: In coarse mode, a valid update u (signed Q8.8) is first rounded to Q4.4 as (u+8)>>>4, where >>> is an arithmetic right shift, so an exact half rounds towards +infinity. The result is clamped to -128..127. It is then added to the state, and the sum is clamped to -128..127.
- R7: In fine mode, a valid update is added to the 16-bit state, and the sum is clamped to -32768..32767.
- R8: On entering fine mode, the state after the update is multiplied by 16 (a Q4.4 to Q8.8 shift).
- R9: On leaving fine mode, the state after the update s becomes (s+8)>>>4, clamped to -128..127.
- R10: The update of a valid sample is applied at the precision of the mode in force before that sample. The new mode applies from the next valid sample onward.
- R11: Without `valid_i`, the mode and the state hold and `mode_chg_o` is 0, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| mag_i | input | 16 | Unsigned Q8.8 magnitude |
| upd_i | input | 16 | Signed Q8.8 update |
| hi_mode_o | output | 1 | 1 means fine (Q8.8) mode |
| mode_chg_o | output | 1 | One-cycle pulse after each mode flip |
| state_o | output | 16 | State; in coarse mode the Q4.4 value, sign-extended |

## Verification
Magnitudes of exactly 26 and 27, then exactly 13 and 12, separate strict comparisons from inclusive ones on each threshold. A long run that alternates 13 and 26 shows that the band never causes a toggle. Update values chosen at rounding halves, just under them, and at full-scale positive and negative exercise the rounding direction and both saturation limits, in accumulation and in requantisation. An update carrying fraction bits on the entry sample shows whether that update was applied at coarse or at fine precision. Idle cycles with large magnitudes on the inputs confirm that nothing moves without the strobe.

// File: rtl/prec_mode_pkg.sv
package prec_mode_pkg;

    typedef enum logic {
        MODE_LO = 1'b0,
        MODE_HI = 1'b1
    } prec_mode_e;

endpackage

// File: rtl/mode_hyst.sv
module mode_hyst
    import prec_mode_pkg::*;
#(
    parameter int MAG_W    = 16,
    parameter int ENTER_TH = 26,
    parameter int EXIT_TH  = 13
) (
    input  prec_mode_e       mode_i,
    input  logic [MAG_W-1:0] mag_i,
    output prec_mode_e       mode_nxt_o
);

    localparam logic [MAG_W-1:0] ENTER_V = MAG_W'(ENTER_TH);
    localparam logic [MAG_W-1:0] EXIT_V  = MAG_W'(EXIT_TH);

    always_comb begin
        mode_nxt_o = mode_i;
        if (mode_i == MODE_LO) begin
            if (mag_i > ENTER_V) mode_nxt_o = MODE_HI;
        end else begin
            if (mag_i < EXIT_V) mode_nxt_o = MODE_LO;
        end
    end

endmodule

// File: rtl/state_unit.sv
module state_unit
    import prec_mode_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int LO_F = 4,
    parameter int HI_W = 16,
    parameter int HI_F = 8
) (
    input  prec_mode_e       mode_cur_i,
    input  prec_mode_e       mode_nxt_i,
    input  logic [HI_W-1:0]  state_i,
    input  logic [HI_W-1:0]  upd_i,
    output logic [HI_W-1:0]  state_o
);

    localparam int SHIFT = HI_F - LO_F;
    localparam int EXT_W = HI_W + 2;
    localparam logic signed [EXT_W-1:0] HALF   = EXT_W'(1) <<< (SHIFT - 1);
    localparam logic signed [EXT_W-1:0] LO_MAX = EXT_W'((1 << (LO_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] LO_MIN = -(EXT_W'(1) <<< (LO_W - 1));
    localparam logic signed [EXT_W-1:0] HI_MAX = EXT_W'((1 << (HI_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] HI_MIN = -(EXT_W'(1) <<< (HI_W - 1));

    function automatic logic signed [EXT_W-1:0] clamp(
        input logic signed [EXT_W-1:0] x,
        input logic signed [EXT_W-1:0] lo,
        input logic signed [EXT_W-1:0] hi
    );
        if (x > hi)      return hi;
        else if (x < lo) return lo;
        else             return x;
    endfunction

    function automatic logic signed [EXT_W-1:0] to_coarse(
        input logic signed [EXT_W-1:0] x
    );
        return clamp((x + HALF) >>> SHIFT, LO_MIN, LO_MAX);
    endfunction

    logic signed [EXT_W-1:0] st_x, up_x, up_lo, sum_lo, sum_hi, post, res;

    always_comb begin
        st_x   = EXT_W'($signed(state_i));
        up_x   = EXT_W'($signed(upd_i));
        up_lo  = to_coarse(up_x);
        sum_lo = clamp(st_x + up_lo, LO_MIN, LO_MAX);
        sum_hi = clamp(st_x + up_x, HI_MIN, HI_MAX);
        post   = (mode_cur_i == MODE_HI) ? sum_hi : sum_lo;
        res    = post;
        if (mode_cur_i == MODE_LO && mode_nxt_i == MODE_HI)
            res = post <<< SHIFT;
        else if (mode_cur_i == MODE_HI && mode_nxt_i == MODE_LO)
            res = to_coarse(post);
        state_o = res[HI_W-1:0];
    end

endmodule

// File: rtl/prec_mode_ctrl.sv
module prec_mode_ctrl
    import prec_mode_pkg::*;
#(
    parameter int LO_W     = 8,
    parameter int LO_F     = 4,
    parameter int HI_W     = 16,
    parameter int HI_F     = 8,
    parameter int ENTER_TH = 26,
    parameter int EXIT_TH  = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [HI_W-1:0] mag_i,
    input  logic [HI_W-1:0] upd_i,
    output logic            hi_mode_o,
    output logic            mode_chg_o,
    output logic [HI_W-1:0] state_o
);

    localparam int SHIFT = HI_F - LO_F;

    typedef struct packed {
        prec_mode_e      mode;
        logic [HI_W-1:0] state;
        logic            chg;
    } regs_t;

    regs_t      r_d, r_q;
    prec_mode_e mode_nxt;
    logic [HI_W-1:0] state_nxt;

    mode_hyst #(
        .MAG_W(HI_W), .ENTER_TH(ENTER_TH), .EXIT_TH(EXIT_TH)
    ) u_hyst (
        .mode_i(r_q.mode), .mag_i(mag_i), .mode_nxt_o(mode_nxt)
    );

    state_unit #(
        .LO_W(LO_W), .LO_F(LO_F), .HI_W(HI_W), .HI_F(HI_F)
    ) u_state (
        .mode_cur_i(r_q.mode), .mode_nxt_i(mode_nxt),
        .state_i(r_q.state), .upd_i(upd_i), .state_o(state_nxt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.chg = 1'b0;
        if (valid_i) begin
            r_d.mode  = mode_nxt;
            r_d.state = state_nxt;
            r_d.chg   = (mode_nxt != r_q.mode);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hi_mode_o  = (r_q.mode == MODE_HI);
    assign mode_chg_o = r_q.chg;
    assign state_o    = r_q.state;

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !hi_mode_o && (mag_i > HI_W'(ENTER_TH)) |=> hi_mode_o);

    assert_leave_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && hi_mode_o && (mag_i < HI_W'(EXIT_TH)) |=> !hi_mode_o);

    assert_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (mag_i >= HI_W'(EXIT_TH)) && (mag_i <= HI_W'(ENTER_TH))
        |=> $stable(hi_mode_o));

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_mode_o != $past(hi_mode_o)) == mode_chg_o);

    assert_coarse_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_mode_o |-> ($signed(state_o) <= $signed(HI_W'((1 << (LO_W - 1)) - 1)))
                    && ($signed(state_o) >= -$signed(HI_W'(1 << (LO_W - 1)))));

    assert_entry_scale_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_mode_o) |-> (state_o[SHIFT-1:0] == '0));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(hi_mode_o) && $stable(state_o) && !mode_chg_o);

endmodule

// File: tb/tb_prec_mode_ctrl.sv
`timescale 1ns/1ps
module tb_prec_mode_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] mag_i = '0;
    logic [15:0] upd_i = '0;
    logic        hi_mode_o, mode_chg_o;
    logic [15:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_hi = 0, m_chg = 0, m_st = 0;

    always #2.5 clk = ~clk;

    prec_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mag_i(mag_i),
        .upd_i(upd_i), .hi_mode_o(hi_mode_o), .mode_chg_o(mode_chg_o),
        .state_o(state_o)
    );

    function automatic int sat(input int x, input int lo, input int hi);
        return (x > hi) ? hi : ((x < lo) ? lo : x);
    endfunction

    function automatic int coarse(input int x);
        return sat((x + 8) >>> 4, -128, 127);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "mode", int'(hi_mode_o), m_hi);
        check(tag, "pulse", int'(mode_chg_o), m_chg);
        check(tag, "state", int'($signed(state_o)), m_st);
    endtask

    task automatic step(input bit v, input int m, input int u, input string tag);
        int nh;
        valid_i = v;
        mag_i   = m[15:0];
        upd_i   = u[15:0];
        @(posedge clk);
        m_chg = 0;
        if (v) begin
            if (m_hi == 0) m_st = sat(m_st + coarse(u), -128, 127);
            else           m_st = sat(m_st + u, -32768, 32767);
            nh = (m_hi == 0) ? ((m > 26) ? 1 : 0) : ((m < 13) ? 0 : 1);
            if (nh != m_hi) begin
                m_st  = (nh == 1) ? m_st * 16 : coarse(m_st);
                m_chg = 1;
                m_hi  = nh;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        step(1, 0, 24, "R6");
        step(1, 0, -9, "R6");
        step(1, 0, -8, "R6");
        step(1, 0, 8, "R6");
        step(1, 0, 32767, "R6");

        step(0, 300, 100, "R11");
        step(0, 5000, -3000, "R11");
        step(0, 0, 1, "R11");

        step(1, 26, 0, "R2");
        step(1, 27, 7, "R10");
        step(1, 27, 0, "R5");
        step(1, 13, 5, "R3");
        step(1, 13, 0, "R7");

        for (int i = 0; i < 20; i++)
            step(1, (i % 2 == 0) ? 26 : 13, 0, "R4");

        step(1, 26, 32767, "R7");
        step(1, 26, 32767, "R7");
        step(1, 12, 0, "R9");

        step(1, 100, 0, "R8");
        step(1, 100, -32768, "R7");
        step(1, 100, -32768, "R7");
        step(1, 0, 0, "R9");

        for (int i = 0; i < 10; i++)
            step(1, (i % 2 == 0) ? 13 : 26, 0, "R4");

        step(1, 200, 0, "R8");
        step(1, 200, 2072, "R7");
        step(1, 0, 0, "R9");
        step(1, 200, 0, "R8");
        step(1, 200, -9, "R7");
        step(1, 0, 0, "R9");
        step(1, 200, 0, "R8");
        step(1, 200, -41, "R7");
        step(1, 0, 0, "R9");
        step(1, 0, -32768, "R6");
        step(0, 900, 1000, "R11");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule